// File: doc/BRIEF.md
# Triple Countdown Interrupt Timer

This block holds three 16-bit down-counters, an interrupt flag register and an interrupt mask register behind a small byte-wide register bus. Software reaches each counter as a low byte and a high byte. Writing the low byte halts that counter and writing the high byte sets it running, so a new value is always written low byte first. A free-running `tick_en` input paces all running counters together: each one steps down by one on every clock cycle in which that input is high.

The first counter keeps a 16-bit reload value. Each time it expires, it reloads from that value and starts again, which gives a periodic interrupt. The second and third counters have no reload storage. Their bytes are written straight into the live count, and after expiring they roll over to 16'hFFFF and keep counting down. Each expiry latches a flag. Any flag that is also unmasked drives a level-sensitive interrupt request and the summary bit 7 of the flag register. Software clears a flag by writing a 1 to its bit.

Top module: `tri_countdown_timer`

## Requirements
- R1: Register offsets are as follows. The first counter uses 0 (low byte) and 1 (high byte), the second uses 2 and 3, and the third uses 4 and 5. The flag register is at 6 and the mask register at 7. Reading a counter offset returns the byte of the live count.
- R2: A write to a counter's low-byte offset stops that counter. A stopped counter holds its value whatever `tick_en` does.
- R3: A write to a counter's high-byte offset starts that counter. For the first counter, the written bytes go into the reload value, and a high-byte write loads the full reload value into the count. For the second and third counters, the written byte goes directly into the count.
- R4: A running counter decrements by one on each cycle in which `tick_en` is 1, and holds on cycles in which it is 0.
- R5: The first counter expires on a tick while its count is 1, or 0. On that tick it reloads the reload value and sets flag bit 3. This repeats for as long as the counter runs.
- R6: The second and third counters expire on a tick that takes the count from 1 to 0. This sets flag bit 4 or flag bit 6 respectively. A tick at count 0 wraps the count to 16'hFFFF, and the counter keeps running.
- R7: Mask register bits 3, 4 and 6 enable the three flags. Only those bits are stored, and its other bits read 0. Flag register bit 7 and `irq` both equal the OR of the flags that are set and enabled. Flag register bits 0, 1, 2 and 5 read 0.
- R8: Writing a 1 to flag bit 3, 4 or 6 clears that flag, and writing a 0 leaves it unchanged. If a flag is set and cleared in the same cycle, it ends up set.
- R9: After reset, all counters are stopped, all counts and the reload value are 0, and the flag and mask registers are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count-step enable for all running counters |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt request |

## Verification
The second counter is loaded with a small start value and stepped in bursts separated by idle gaps. This separates decrementing only on ticks from decrementing every cycle, and it also shows expiry at 1→0 and the wrap to 16'hFFFF. The first counter is run through more than one period, which separates reload-and-repeat from a one-shot count. A flag clear is issued on the same cycle as an expiry, which shows whether set or clear wins. The mask is written with all ones and then with single bits, which separates storing only the three real bits from storing the whole byte. It also shows that a set but masked flag stays visible without raising `irq`.

// File: rtl/tri_countdown_timer.sv
`timescale 1ns/1ps
module tri_countdown_timer #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int CNT_W = 2 * DATA_W;
  localparam int NTMR = 3;
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(7);
  localparam int B_T1 = 3, B_T2 = 4, B_T3 = 6, B_SUM = 7;

  logic [CNT_W-1:0] count [NTMR];
  logic [NTMR-1:0]  running, expire, flags, mask;
  logic [CNT_W-1:0] reload1;
  logic             flag_wr;
  logic [NTMR-1:0]  wsel;

  assign flag_wr = bus_wr && bus_addr == A_FLAG;
  assign wsel = {bus_wdata[B_T3], bus_wdata[B_T2], bus_wdata[B_T1]};

  for (genvar g = 0; g < NTMR; g++) begin : g_tmr
    localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(2 * g);
    localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(2 * g + 1);
    logic wr_lo, wr_hi, step;
    logic [CNT_W-1:0] cnt_q;

    assign wr_lo = bus_wr && bus_addr == A_LO;
    assign wr_hi = bus_wr && bus_addr == A_HI;
    assign step  = running[g] && tick_en;
    assign count[g] = cnt_q;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)     running[g] <= 1'b0;
      else if (wr_lo) running[g] <= 1'b0;
      else if (wr_hi) running[g] <= 1'b1;

    if (g == 0) begin : g_reload
      logic [CNT_W-1:0] rld_q;
      assign reload1 = rld_q;
      assign expire[g] = step && cnt_q <= CNT_W'(1);

      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) rld_q <= '0;
        else if (wr_lo) rld_q[DATA_W-1:0] <= bus_wdata;
        else if (wr_hi) rld_q[CNT_W-1:DATA_W] <= bus_wdata;

      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)         cnt_q <= '0;
        else if (wr_hi)     cnt_q <= {bus_wdata, rld_q[DATA_W-1:0]};
        else if (wr_lo)     cnt_q <= cnt_q;
        else if (expire[g]) cnt_q <= rld_q;
        else if (step)      cnt_q <= cnt_q - 1'b1;
    end else begin : g_free
      assign expire[g] = step && cnt_q == CNT_W'(1);

      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)     cnt_q <= '0;
        else if (wr_lo) cnt_q[DATA_W-1:0] <= bus_wdata;
        else if (wr_hi) cnt_q[CNT_W-1:DATA_W] <= bus_wdata;
        else if (step)  cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flags <= '0;
    else        flags <= expire | (flags & ~(wsel & {NTMR{flag_wr}}));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                               mask <= '0;
    else if (bus_wr && bus_addr == A_MASK)    mask <= wsel;

  assign irq = |(flags & mask);

  function automatic logic [DATA_W-1:0] spread(input logic [NTMR-1:0] v, input logic top);
    logic [DATA_W-1:0] r;
    r = '0;
    r[B_T1] = v[0];
    r[B_T2] = v[1];
    r[B_T3] = v[2];
    r[B_SUM] = top;
    return r;
  endfunction

  always_comb begin
    case (bus_addr)
      ADDR_W'(0): bus_rdata = count[0][DATA_W-1:0];
      ADDR_W'(1): bus_rdata = count[0][CNT_W-1:DATA_W];
      ADDR_W'(2): bus_rdata = count[1][DATA_W-1:0];
      ADDR_W'(3): bus_rdata = count[1][CNT_W-1:DATA_W];
      ADDR_W'(4): bus_rdata = count[2][DATA_W-1:0];
      ADDR_W'(5): bus_rdata = count[2][CNT_W-1:DATA_W];
      A_FLAG:     bus_rdata = spread(flags, irq);
      default:    bus_rdata = spread(mask, 1'b0);
    endcase
  end
endmodule

module tri_countdown_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick_en,
  input logic [2:0]  bus_addr,
  input logic        bus_wr,
  input logic [7:0]  bus_wdata,
  input logic [7:0]  bus_rdata,
  input logic        irq,
  input logic [15:0] count [3],
  input logic [2:0]  running,
  input logic [2:0]  flags,
  input logic [15:0] reload1
);
  AST_FLAG_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == 3'd6 |-> bus_rdata[7] == irq); // R7
  AST_LOW_WRITE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == 3'd2 |=> !running[1]); // R2
  AST_HIGH_WRITE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == 3'd5 |=> running[2]); // R3
  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !running[1] && !(bus_wr && (bus_addr == 3'd2 || bus_addr == 3'd3)) |=> $stable(count[1])); // R2
  AST_IDLE_TICK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    running[2] && !tick_en && !(bus_wr && (bus_addr == 3'd4 || bus_addr == 3'd5)) |=> $stable(count[2])); // R4
  AST_T1_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    running[0] && tick_en && count[0] == 16'd1 && !(bus_wr && bus_addr <= 3'd1) |=> count[0] == reload1 && flags[0]); // R5
  AST_WRAP_KEEPS_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    running[2] && tick_en && count[2] == 16'd0 && !(bus_wr && (bus_addr == 3'd4 || bus_addr == 3'd5)) |=> count[2] == 16'hFFFF && running[2]); // R6
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == 3'd6 && bus_wdata[4] && !(running[1] && tick_en && count[1] == 16'd1) |=> !flags[1]); // R8
endmodule

bind tri_countdown_timer tri_countdown_timer_chk u_chk (.*);

// File: tb/tb_tri_countdown_timer.sv
`timescale 1ns/1ps
module tb_tri_countdown_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0;
  logic [2:0] bus_addr = '0;
  logic bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic irq;

  always #2.5 clk = ~clk;

  tri_countdown_timer dut (.*);

  typedef struct {
    logic [2:0] addr;
    logic [7:0] data;
    logic       irq;
    string      tag;
  } item_t;

  item_t sbq[$];
  event mon_ev;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  initial forever begin
    item_t it;
    @(mon_ev);
    it = sbq.pop_front();
    checks++;
    if (bus_rdata !== it.data || irq !== it.irq) begin
      fails++;
      $display("FAIL %s: addr=%0d rdata=%h irq=%b expected rdata=%h irq=%b",
               it.tag, it.addr, bus_rdata, irq, it.data, it.irq);
    end
  end

  task automatic expect_rd(input logic [2:0] a, input logic [7:0] d, input logic i, input string tag);
    item_t it;
    @(negedge clk);
    bus_addr = a;
    bus_wr = 1'b0;
    it.addr = a; it.data = d; it.irq = i; it.tag = tag;
    sbq.push_back(it);
    #0.5 ->mon_ev;
    #0.5;
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wr_with_tick(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; tick_en = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; tick_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 8; a++) expect_rd(3'(a), 8'h00, 1'b0, "R9 reset value");

    wr_reg(3'd2, 8'h05);
    wr_reg(3'd3, 8'h00);
    expect_rd(3'd2, 8'h05, 1'b0, "R3 start value t2");
    ticks(3);
    expect_rd(3'd2, 8'h02, 1'b0, "R4 decrement per tick");
    repeat (3) @(negedge clk);
    expect_rd(3'd2, 8'h02, 1'b0, "R4 hold without tick");
    ticks(2);
    expect_rd(3'd2, 8'h00, 1'b0, "R6 t2 reached zero");
    expect_rd(3'd6, 8'h10, 1'b0, "R6 t2 flag masked");
    ticks(1);
    expect_rd(3'd2, 8'hFF, 1'b0, "R6 t2 wrap low");
    expect_rd(3'd3, 8'hFF, 1'b0, "R6 t2 wrap high");

    wr_reg(3'd7, 8'h10);
    expect_rd(3'd6, 8'h90, 1'b1, "R7 enabled flag drives irq");
    expect_rd(3'd7, 8'h10, 1'b1, "R7 mask readback");
    wr_reg(3'd7, 8'hFF);
    expect_rd(3'd7, 8'h58, 1'b1, "R7 mask stores only bits 3,4,6");

    wr_reg(3'd6, 8'h00);
    expect_rd(3'd6, 8'h90, 1'b1, "R8 zero write ignored");
    wr_reg(3'd6, 8'h10);
    expect_rd(3'd6, 8'h00, 1'b0, "R8 write one clears");

    wr_reg(3'd2, 8'h34);
    ticks(5);
    expect_rd(3'd2, 8'h34, 1'b0, "R2 stopped low byte");
    expect_rd(3'd3, 8'hFF, 1'b0, "R2 stopped high byte");

    wr_reg(3'd0, 8'h03);
    wr_reg(3'd1, 8'h00);
    expect_rd(3'd0, 8'h03, 1'b0, "R3 t1 loads reload");
    ticks(2);
    expect_rd(3'd0, 8'h01, 1'b0, "R4 t1 count");
    expect_rd(3'd6, 8'h00, 1'b0, "R5 no flag before expiry");
    ticks(1);
    expect_rd(3'd6, 8'h88, 1'b1, "R5 t1 flag");
    expect_rd(3'd0, 8'h03, 1'b1, "R5 t1 reloaded");
    ticks(3);
    expect_rd(3'd0, 8'h03, 1'b1, "R5 t1 reloads again");
    wr_reg(3'd6, 8'h08);
    expect_rd(3'd6, 8'h00, 1'b0, "R8 clear t1 flag");
    ticks(2);
    wr_with_tick(3'd6, 8'h08);
    expect_rd(3'd6, 8'h88, 1'b1, "R8 set wins over clear");
    expect_rd(3'd0, 8'h03, 1'b1, "R5 reload on clear cycle");

    wr_reg(3'd0, 8'h03);
    ticks(4);
    expect_rd(3'd0, 8'h03, 1'b1, "R2 t1 stopped");
    expect_rd(3'd1, 8'h00, 1'b1, "R1 t1 high byte");
    wr_reg(3'd6, 8'h08);

    wr_reg(3'd7, 8'h40);
    wr_reg(3'd4, 8'h02);
    wr_reg(3'd5, 8'h00);
    ticks(1);
    expect_rd(3'd4, 8'h01, 1'b0, "R4 t3 count");
    expect_rd(3'd6, 8'h00, 1'b0, "R6 t3 no early flag");
    ticks(1);
    expect_rd(3'd6, 8'hC0, 1'b1, "R6 t3 flag enabled");
    expect_rd(3'd5, 8'h00, 1'b1, "R1 t3 high byte zero");
    ticks(1);
    expect_rd(3'd4, 8'hFF, 1'b1, "R6 t3 wrap low");
    expect_rd(3'd5, 8'hFF, 1'b1, "R6 t3 wrap high");
    wr_reg(3'd7, 8'h00);
    expect_rd(3'd6, 8'h40, 1'b0, "R7 masked flag visible");
    wr_reg(3'd6, 8'h40);
    expect_rd(3'd6, 8'h00, 1'b0, "R8 t3 flag cleared");
    expect_rd(3'd2, 8'h34, 1'b0, "R2 t2 still stopped");

    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule